// File: doc/BRIEF.md
# Digital Phase Lock Detector

This block decides whether a phase-locked loop has settled. It watches the rising edges of the reference clock and the feedback clock as they arrive at the phase-frequency detector, and it runs on a sampling clock much faster than either of them. For every detector cycle it counts how many sampling-clock ticks separate the two rising edges, and it compares that count with a programmable lock window.

Lock is declared only after a selectable number of detector cycles in a row have landed inside the window. After that, the flag stays up until an edge separation goes past a second, wider threshold. The gap between the two thresholds gives the flag hysteresis, so a marginal loop does not make it toggle.

Both edge inputs pass through two synchronizing flip-flops before their rising edges are detected. A disable input forces the flag low and holds the qualifier in its idle state.

Top module: `pll_lock_detector`

## Requirements
- R1: While reset is held and straight after it is released, `lock_o` is low.
- R2: `run_sel_i` sets how many consecutive in-window detector cycles declare lock: 0 selects 5, 1 selects 16, 2 selects 64 and 3 selects 255. `lock_o` rises after the cycle that completes the run. It stays low after one cycle fewer.
- R3: A detector cycle counts toward lock only when the edge separation in ticks is strictly smaller than the window. With `range_lo_i`=0 the window is WIN_HI (default 8) and the loss threshold is LOSS_HI (default 16). With `range_lo_i`=1 they are WIN_LO (default 3) and LOSS_LO (default 6).
- R4: Any detector cycle outside the window that occurs before lock is declared restarts the run from zero.
- R5: Once `lock_o` is high it stays high for every separation up to and including the loss threshold. A separation greater than the loss threshold drops it.
- R6: If one edge arrives and the other has not followed within the loss threshold, the cycle counts as beyond the loss threshold.
- R7: While `detect_off_i` is 1, `lock_o` is low and the run count is zero. After `detect_off_i` returns to 0, a full new run is needed to lock.
- R8: The separation is the absolute tick count between the two rising edges, whichever edge comes first. Each detector cycle yields exactly one single-cycle measurement.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk_i | input | 1 | Fast sampling clock |
| rst_ni | input | 1 | Active-low synchronous reset |
| ref_edge_i | input | 1 | Reference clock at the detector input (asynchronous) |
| fb_edge_i | input | 1 | Feedback clock at the detector input (asynchronous) |
| run_sel_i | input | 2 | Consecutive-cycle count select (0:5, 1:16, 2:64, 3:255) |
| range_lo_i | input | 1 | 0 selects the high window range, 1 selects the low range |
| detect_off_i | input | 1 | 1 disables lock detection |
| lock_o | output | 1 | Lock flag |

## Verification
The hardest situations to reach from the ports are the threshold edges. One is a separation exactly equal to the loss threshold, which must not drop lock; another, one tick more, must drop it. A third is a late or missing second edge, where the timeout path rather than an edge closes the measurement. The bench builds each detector cycle tick by tick on the sampling clock, so the feedback edge sits at any signed offset from the reference edge or is left out. It sweeps every offset in both ranges against a bench-side model of the run and the flag, and it runs the 255-cycle run to completion.

// File: rtl/pld_pkg.sv
package pld_pkg;

    typedef enum logic [1:0] {
        M_IDLE     = 2'd0,
        M_WAIT_FB  = 2'd1,
        M_WAIT_REF = 2'd2
    } meas_state_e;

    typedef enum logic [1:0] {
        Q_OFF    = 2'd0,
        Q_SEARCH = 2'd1,
        Q_LOCKED = 2'd2
    } qual_state_e;

    localparam int RUN_W = 8;

    function automatic logic [RUN_W-1:0] run_target(input logic [1:0] sel);
        logic [RUN_W-1:0] t;
        unique case (sel)
            2'd0:    t = RUN_W'(5);
            2'd1:    t = RUN_W'(16);
            2'd2:    t = RUN_W'(64);
            default: t = RUN_W'(255);
        endcase
        return t;
    endfunction

endpackage

// File: rtl/pld_edge_sync.sv
module pld_edge_sync #(
    parameter int STAGES = 2
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic d_i,
    output logic rise_o
);
    // STAGES synchronizer flops plus one history flop for edge detection
    logic [STAGES:0] sh_q;

    always_ff @(posedge clk_i) begin
        if (!rst_ni) sh_q <= '0;
        else         sh_q <= {sh_q[STAGES-1:0], d_i};
    end

    assign rise_o = sh_q[STAGES-1] & ~sh_q[STAGES];
endmodule

// File: rtl/pld_meas.sv
module pld_meas
    import pld_pkg::*;
#(
    parameter int WIN_HI  = 8,
    parameter int LOSS_HI = 16,
    parameter int WIN_LO  = 3,
    parameter int LOSS_LO = 6
) (
    input  logic clk_i,
    input  logic rst_ni,
    input  logic range_lo_i,
    input  logic ref_rise_i,
    input  logic fb_rise_i,
    output logic sample_vld_o,
    output logic in_win_o,
    output logic beyond_o
);
    localparam int LOSS_MAX = (LOSS_HI > LOSS_LO) ? LOSS_HI : LOSS_LO;
    localparam int CW       = $clog2(LOSS_MAX + 2);

    meas_state_e   state, state_n;
    logic [CW-1:0] cnt_q, cnt_n;
    logic [CW-1:0] win, loss, delta;
    logic          emit, miss;

    assign win  = range_lo_i ? CW'(WIN_LO)  : CW'(WIN_HI);
    assign loss = range_lo_i ? CW'(LOSS_LO) : CW'(LOSS_HI);

    always_comb begin
        state_n = state;
        cnt_n   = cnt_q;
        emit    = 1'b0;
        miss    = 1'b0;
        delta   = cnt_q;
        unique case (state)
            M_IDLE: begin
                if (ref_rise_i && fb_rise_i) begin
                    emit  = 1'b1;
                    delta = '0;
                end else if (ref_rise_i) begin
                    state_n = M_WAIT_FB;
                    cnt_n   = CW'(1);
                end else if (fb_rise_i) begin
                    state_n = M_WAIT_REF;
                    cnt_n   = CW'(1);
                end
            end
            M_WAIT_FB: begin
                if (fb_rise_i) begin
                    emit    = 1'b1;
                    state_n = M_IDLE;
                end else if (cnt_q >= loss) begin
                    emit    = 1'b1;
                    miss    = 1'b1;
                    state_n = M_IDLE;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            M_WAIT_REF: begin
                if (ref_rise_i) begin
                    emit    = 1'b1;
                    state_n = M_IDLE;
                end else if (cnt_q >= loss) begin
                    emit    = 1'b1;
                    miss    = 1'b1;
                    state_n = M_IDLE;
                end else begin
                    cnt_n = cnt_q + CW'(1);
                end
            end
            default: state_n = M_IDLE;
        endcase
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state <= M_IDLE;
            cnt_q <= '0;
        end else begin
            state <= state_n;
            cnt_q <= cnt_n;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            sample_vld_o <= 1'b0;
            in_win_o     <= 1'b0;
            beyond_o     <= 1'b0;
        end else begin
            sample_vld_o <= emit;
            in_win_o     <= emit && !miss && (delta < win);
            beyond_o     <= emit && (miss || (delta > loss));
        end
    end
endmodule

// File: rtl/pld_qual.sv
module pld_qual
    import pld_pkg::*;
(
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       detect_off_i,
    input  logic [1:0] run_sel_i,
    input  logic       sample_vld_i,
    input  logic       in_win_i,
    input  logic       beyond_i,
    output logic       lock_o
);
    qual_state_e      state, state_n;
    logic [RUN_W-1:0] run_q, run_n;
    logic [RUN_W:0]   run_inc;
    logic [RUN_W-1:0] target;

    assign target  = run_target(run_sel_i);
    assign run_inc = {1'b0, run_q} + (RUN_W+1)'(1);

    always_comb begin
        state_n = state;
        run_n   = run_q;
        unique case (state)
            Q_OFF: begin
                state_n = Q_SEARCH;
                run_n   = '0;
            end
            Q_SEARCH: begin
                if (sample_vld_i) begin
                    if (!in_win_i) begin
                        run_n = '0;
                    end else if (run_inc >= {1'b0, target}) begin
                        state_n = Q_LOCKED;
                        run_n   = '0;
                    end else begin
                        run_n = run_inc[RUN_W-1:0];
                    end
                end
            end
            Q_LOCKED: begin
                if (sample_vld_i && beyond_i) begin
                    state_n = Q_SEARCH;
                    run_n   = '0;
                end
            end
            default: begin
                state_n = Q_SEARCH;
                run_n   = '0;
            end
        endcase
        if (detect_off_i) begin
            state_n = Q_OFF;
            run_n   = '0;
        end
    end

    always_ff @(posedge clk_i) begin
        if (!rst_ni) begin
            state <= Q_SEARCH;
            run_q <= '0;
        end else begin
            state <= state_n;
            run_q <= run_n;
        end
    end

    always_comb begin
        lock_o = (state == Q_LOCKED);
    end
endmodule

// File: rtl/pll_lock_detector.sv
module pll_lock_detector #(
    parameter int WIN_HI      = 8,
    parameter int LOSS_HI     = 16,
    parameter int WIN_LO      = 3,
    parameter int LOSS_LO     = 6,
    parameter int SYNC_STAGES = 2
) (
    input  logic       clk_i,
    input  logic       rst_ni,
    input  logic       ref_edge_i,
    input  logic       fb_edge_i,
    input  logic [1:0] run_sel_i,
    input  logic       range_lo_i,
    input  logic       detect_off_i,
    output logic       lock_o
);
    localparam int NCH = 2;

    logic [NCH-1:0] raw;
    logic [NCH-1:0] rise;
    logic           meas_vld, meas_in_win, meas_beyond;

    assign raw = {fb_edge_i, ref_edge_i};

    for (genvar g = 0; g < NCH; g++) begin : g_sync
        pld_edge_sync #(.STAGES(SYNC_STAGES)) u_sync (
            .clk_i  (clk_i),
            .rst_ni (rst_ni),
            .d_i    (raw[g]),
            .rise_o (rise[g])
        );
    end

    pld_meas #(
        .WIN_HI (WIN_HI),
        .LOSS_HI(LOSS_HI),
        .WIN_LO (WIN_LO),
        .LOSS_LO(LOSS_LO)
    ) u_meas (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .range_lo_i   (range_lo_i),
        .ref_rise_i   (rise[0]),
        .fb_rise_i    (rise[1]),
        .sample_vld_o (meas_vld),
        .in_win_o     (meas_in_win),
        .beyond_o     (meas_beyond)
    );

    pld_qual u_qual (
        .clk_i        (clk_i),
        .rst_ni       (rst_ni),
        .detect_off_i (detect_off_i),
        .run_sel_i    (run_sel_i),
        .sample_vld_i (meas_vld),
        .in_win_i     (meas_in_win),
        .beyond_i     (meas_beyond),
        .lock_o       (lock_o)
    );
endmodule

// File: rtl/pld_lock_checker.sv
module pld_lock_checker (
    input logic clk_i,
    input logic rst_ni,
    input logic detect_off_i,
    input logic lock_o,
    input logic sample_vld,
    input logic in_win,
    input logic beyond
);
    // R7: a disable seen on the previous edge leaves the flag low
    assert_off_forces_low_R7: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $past(detect_off_i) |-> !lock_o);

    // R2, R3: lock is only ever declared right after an in-window measurement
    assert_rise_after_in_window_R2: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $rose(lock_o) |-> $past(sample_vld && in_win));

    // R5: lock is only lost after a beyond-threshold measurement or a disable
    assert_fall_needs_beyond_R5: assert property (@(posedge clk_i) disable iff (!rst_ni)
        $fell(lock_o) |-> ($past(sample_vld && beyond) || $past(detect_off_i)));

    // R8: one single-cycle measurement per detector cycle
    assert_single_sample_R8: assert property (@(posedge clk_i) disable iff (!rst_ni)
        sample_vld |=> !sample_vld);
endmodule

bind pll_lock_detector pld_lock_checker u_chk (
    .clk_i        (clk_i),
    .rst_ni       (rst_ni),
    .detect_off_i (detect_off_i),
    .lock_o       (lock_o),
    .sample_vld   (meas_vld),
    .in_win       (meas_in_win),
    .beyond       (meas_beyond)
);

// File: tb/pll_lock_detector_tb_top.sv
module pll_lock_detector_tb_top;
    localparam int WHI = 8, LHI = 16, WLO = 3, LLO = 6;
    localparam int PERIOD_T = 48, BASE_T = 16, PW = 3;

    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       ref_e = 1'b0, fb_e = 1'b0;
    logic [1:0] sel = 2'd0;
    logic       rlo = 1'b0, off = 1'b0;
    logic       lock;

    int errors = 0, checks = 0;
    bit done = 1'b0;
    bit m_lock = 1'b0;
    int m_run = 0;

    always #5 clk = ~clk;

    pll_lock_detector #(.WIN_HI(WHI), .LOSS_HI(LHI), .WIN_LO(WLO), .LOSS_LO(LLO)) dut_i (
        .clk_i(clk), .rst_ni(rst_n), .ref_edge_i(ref_e), .fb_edge_i(fb_e),
        .run_sel_i(sel), .range_lo_i(rlo), .detect_off_i(off), .lock_o(lock)
    );

    function automatic int tgt(input logic [1:0] s);
        case (s)
            2'd0: return 5;
            2'd1: return 16;
            2'd2: return 64;
            default: return 255;
        endcase
    endfunction

    task automatic check(input string req, input logic act, input logic exp);
        checks++;
        if (act !== exp) begin
            errors++;
            $display("FAIL %s: lock actual=%0b expected=%0b", req, act, exp);
        end
    endtask

    // One detector cycle; d is the signed feedback offset in ticks, miss omits feedback
    task automatic det_cycle(input int d, input bit miss, input string req);
        int ad, w, l;
        bit inw, bey;
        for (int t = 0; t < PERIOD_T; t++) begin
            @(negedge clk);
            ref_e = (t >= BASE_T) && (t < BASE_T + PW);
            fb_e  = !miss && (t >= BASE_T + d) && (t < BASE_T + d + PW);
        end
        @(negedge clk);
        ad  = (d < 0) ? -d : d;
        w   = rlo ? WLO : WHI;
        l   = rlo ? LLO : LHI;
        inw = !miss && (ad < w);
        bey = miss || (ad > l);
        if (off) begin
            m_lock = 1'b0; m_run = 0;
        end else if (!m_lock) begin
            if (inw) begin
                m_run++;
                if (m_run >= tgt(sel)) begin m_lock = 1'b1; m_run = 0; end
            end else m_run = 0;
        end else if (bey) begin
            m_lock = 1'b0; m_run = 0;
        end
        check(req, lock, m_lock);
    endtask

    initial begin
        repeat (4) @(negedge clk);
        check("R1", lock, 1'b0);
        rst_n = 1'b1;
        @(negedge clk);
        check("R1", lock, 1'b0);

        // R2: default run of 5
        for (int i = 0; i < 6; i++) det_cycle(0, 1'b0, "R2");

        // R3 / R8: every signed offset in both ranges
        for (int r = 0; r < 2; r++) begin
            rlo = r[0];
            for (int d = -14; d <= 14; d++)
                for (int k = 0; k < 3; k++) det_cycle(d, 1'b0, (d < 0) ? "R8" : "R3");
            det_cycle(0, 1'b1, "R6");
        end

        // R5: low range, equal to loss threshold holds, one more drops
        rlo = 1'b1;
        for (int i = 0; i < 5; i++) det_cycle(1, 1'b0, "R5");
        det_cycle(LLO, 1'b0, "R5");
        det_cycle(-LLO, 1'b0, "R5");
        det_cycle(4, 1'b0, "R5");
        det_cycle(LLO + 1, 1'b0, "R5");

        // R4: out-of-window cycle breaks the run
        for (int i = 0; i < 4; i++) det_cycle(2, 1'b0, "R4");
        det_cycle(4, 1'b0, "R4");
        for (int i = 0; i < 4; i++) det_cycle(-2, 1'b0, "R4");
        det_cycle(2, 1'b0, "R4");

        // R6: missing feedback while locked drops lock (high range)
        rlo = 1'b0;
        det_cycle(LHI, 1'b0, "R5");
        det_cycle(0, 1'b1, "R6");

        // R2: longer runs
        for (int s = 1; s < 4; s++) begin
            sel = s[1:0];
            det_cycle(0, 1'b1, "R2");
            for (int i = 0; i < tgt(sel) + 1; i++) det_cycle(1, 1'b0, "R2");
        end

        // R7: disable while locked, then a fresh run is needed
        sel = 2'd0;
        det_cycle(3, 1'b0, "R7");
        off = 1'b1;
        @(negedge clk); @(negedge clk);
        check("R7", lock, 1'b0);
        det_cycle(0, 1'b0, "R7");
        det_cycle(0, 1'b0, "R7");
        off = 1'b0;
        for (int i = 0; i < 6; i++) det_cycle(0, 1'b0, "R7");

        done = 1'b1;
        $display("Result: errors=%0d of %0d checks", errors, checks);
        $finish;
    end

    initial begin
        repeat (190000) @(posedge clk);
        if (!done) begin
            checks++;
            errors++;
            $display("FAIL watchdog: actual=hung expected=finished");
            $display("Result: errors=%0d of %0d checks", errors, checks);
            $finish;
        end
    end
endmodule